// File: doc/BRIEF.md
# Tag Command Receiver with Even-Parity Check

This block receives commands that a reader sends to a passive tag during the tag's listening window. It samples a demodulated "modulation present" input once per half-bit tick. It accepts a start only at permitted bit positions of the window, and it expects every command to open with a Manchester 0 marker. It then decodes a 6-bit command code. When the command carries a payload, it also decodes a 32-bit word and one parity bit.

For a command with a payload, the ones across the 39 received bits must be even in number. A good command is presented with a one-cycle valid strobe. A parity failure or a coding violation gives a one-cycle abort instead, and the frame sequencer uses that abort to return to the identity broadcast. An external command decoder tells the receiver, through one input, whether the code just received is followed by a payload. The receiver raises a busy signal from start detection until the outcome. The frame sequencer holds its own progress while busy is high.

Top module: `tag_cmd_rx`

## Requirements
- R1: A start is accepted only when the receiver is idle, a half-bit tick arrives with modulation sampled high, and the window-active input is high. Without the window, such modulation leaves busy low and produces no strobe.
- R2: Window bit positions 0 and 7 are masked and never start reception. Positions 1 through 6 inclusive all start it.
- R3: The start marker is a Manchester 0: modulation in its first half and none in its second. If the second half also shows modulation, the receiver aborts.
- R4: Each later bit is built from two half samples. Modulation then none is 0, and none then modulation is 1. Two equal halves are a coding violation and abort the reception.
- R5: The six bits after the marker form `cmd_code`, first received bit in bit 5 (MSB first).
- R6: `has_data` is sampled in the cycle after the sixth command bit, while `cmd_code` holds the full code. When it is low, `cmd_valid` pulses with `cmd_data` equal to zero, and no parity bit is expected.
- R7: When `has_data` is high, 32 data bits follow MSB first (first in bit 31), then one parity bit. If the count of ones over code, data and parity is even, `cmd_valid` pulses with the code and data.
- R8: If that count is odd, `abort` pulses and `cmd_valid` does not.
- R9: `cmd_valid` and `abort` each last exactly one cycle and never assert together.
- R10: `busy` rises in the cycle after start detection and falls in the cycle in which `cmd_valid` or `abort` asserts. While busy, window and modulation activity cannot start a new reception.
- R11: After reset, `busy`, `cmd_valid` and `abort` are low and `cmd_code` and `cmd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_in | input | 1 | Sampled demodulated modulation-present flag |
| half_tick | input | 1 | One-cycle pulse once per half-bit time |
| win_active | input | 1 | High while the listening window runs |
| win_idx | input | 3 | Bit position within the listening window |
| has_data | input | 1 | From command decode: a payload follows the code |
| busy | output | 1 | Reception in progress; pauses the frame sequencer |
| cmd_valid | output | 1 | One-cycle strobe: command accepted |
| abort | output | 1 | One-cycle strobe: reception discarded |
| cmd_code | output | 6 | Received command code |
| cmd_data | output | 32 | Received payload word |

## Verification
The last half of the parity bit can complete a command in the same cycle that a start would otherwise be qualified. When the parity bit is a 1, its second half carries modulation. The bench provokes this by holding the window active at an allowed position while that half is sent. It then judges that exactly one valid strobe appears, that no abort follows, and that busy is low afterwards.

// File: rtl/tag_rx_pkg.sv
package tag_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_MARK,
    RX_CMD,
    RX_DECIDE,
    RX_DATA
  } rx_state_e;

  // Two half-bit samples -> {violation, bit}
  function automatic logic [1:0] manch_decode(input logic first_h, input logic second_h);
    logic viol;
    viol = (first_h == second_h);
    return {viol, second_h};
  endfunction

  // True when the number of ones over code, word and parity is even
  function automatic logic parity_even(input logic [5:0] code, input logic [31:0] word,
                                       input logic pbit);
    return ~(^{code, word, pbit});
  endfunction

endpackage

// File: rtl/rx_start_qual.sv
module rx_start_qual #(
  parameter int WIN_W  = 3,
  parameter int WIN_LO = 1,
  parameter int WIN_HI = 6
) (
  input  logic             idle,
  input  logic             half_tick,
  input  logic             mod_in,
  input  logic             win_active,
  input  logic [WIN_W-1:0] win_idx,
  output logic             start_hit
);
  logic in_span;

  always_comb begin
    in_span   = (win_idx >= WIN_W'(WIN_LO)) && (win_idx <= WIN_W'(WIN_HI));
    start_hit = idle && half_tick && mod_in && win_active && in_span;
  end
endmodule

// File: rtl/rx_half_pair.sv
module rx_half_pair
  import tag_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic preload,
  input  logic half_tick,
  input  logic mod_in,
  output logic sym_stb,
  output logic sym_bit,
  output logic sym_viol
);
  logic phase;
  logic first_h;
  logic [1:0] dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= 1'b0;
      first_h <= 1'b0;
    end else if (preload) begin
      // start half already seen: modulation in the first half
      phase   <= 1'b1;
      first_h <= 1'b1;
    end else if (!en) begin
      phase   <= 1'b0;
    end else if (half_tick) begin
      if (!phase) first_h <= mod_in;
      phase <= ~phase;
    end
  end

  always_comb begin
    dec      = manch_decode(first_h, mod_in);
    sym_stb  = en && half_tick && phase;
    sym_viol = dec[1];
    sym_bit  = dec[0];
  end
endmodule

// File: rtl/rx_cmd_fsm.sv
module rx_cmd_fsm
  import tag_rx_pkg::*;
#(
  parameter int CMD_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_hit,
  input  logic              sym_stb,
  input  logic              sym_bit,
  input  logic              sym_viol,
  input  logic              has_data,
  output logic              busy,
  output logic              cmd_valid,
  output logic              abort,
  output logic [CMD_W-1:0]  cmd_code,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             last_cmd;
  logic             last_data;
  logic             par_ok;

  always_comb begin
    busy      = (state != RX_IDLE);
    last_cmd  = (cnt == CNT_W'(CMD_W - 1));
    last_data = (cnt == CNT_W'(DATA_W));
    par_ok    = parity_even(cmd_code, cmd_data, sym_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      cmd_valid <= 1'b0;
      abort     <= 1'b0;
      cmd_code  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      abort     <= 1'b0;
      case (state)
        RX_IDLE: if (start_hit) begin
          state    <= RX_MARK;
          cnt      <= '0;
          cmd_code <= '0;
          cmd_data <= '0;
        end
        RX_MARK: if (sym_stb) begin
          if (sym_viol || sym_bit) begin
            abort <= 1'b1;
            state <= RX_IDLE;
          end else begin
            state <= RX_CMD;
          end
        end
        RX_CMD: if (sym_stb) begin
          if (sym_viol) begin
            abort <= 1'b1;
            state <= RX_IDLE;
          end else begin
            cmd_code <= {cmd_code[CMD_W-2:0], sym_bit};
            if (last_cmd) begin
              cnt   <= '0;
              state <= RX_DECIDE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_DECIDE: begin
          if (has_data) begin
            state <= RX_DATA;
          end else begin
            cmd_valid <= 1'b1;
            state     <= RX_IDLE;
          end
        end
        RX_DATA: if (sym_stb) begin
          if (sym_viol) begin
            abort <= 1'b1;
            state <= RX_IDLE;
          end else if (last_data) begin
            cmd_valid <= par_ok;
            abort     <= ~par_ok;
            state     <= RX_IDLE;
          end else begin
            cmd_data <= {cmd_data[DATA_W-2:0], sym_bit};
            cnt      <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  AST_ODD_PARITY_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DATA && sym_stb && !sym_viol && last_data && !par_ok) |=> (abort && !cmd_valid)); // R8

  AST_CODE_HELD_AT_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DECIDE) |=> $stable(cmd_code)); // R6
endmodule

// File: rtl/tag_cmd_rx.sv
module tag_cmd_rx #(
  parameter int CMD_W  = 6,
  parameter int DATA_W = 32,
  parameter int WIN_W  = 3,
  parameter int WIN_LO = 1,
  parameter int WIN_HI = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_in,
  input  logic              half_tick,
  input  logic              win_active,
  input  logic [WIN_W-1:0]  win_idx,
  input  logic              has_data,
  output logic              busy,
  output logic              cmd_valid,
  output logic              abort,
  output logic [CMD_W-1:0]  cmd_code,
  output logic [DATA_W-1:0] cmd_data
);
  logic start_hit;
  logic sym_stb;
  logic sym_bit;
  logic sym_viol;

  rx_start_qual #(.WIN_W(WIN_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_qual (
    .idle       (~busy),
    .half_tick  (half_tick),
    .mod_in     (mod_in),
    .win_active (win_active),
    .win_idx    (win_idx),
    .start_hit  (start_hit)
  );

  rx_half_pair u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (busy),
    .preload   (start_hit),
    .half_tick (half_tick),
    .mod_in    (mod_in),
    .sym_stb   (sym_stb),
    .sym_bit   (sym_bit),
    .sym_viol  (sym_viol)
  );

  rx_cmd_fsm #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_hit (start_hit),
    .sym_stb   (sym_stb),
    .sym_bit   (sym_bit),
    .sym_viol  (sym_viol),
    .has_data  (has_data),
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .abort     (abort),
    .cmd_code  (cmd_code),
    .cmd_data  (cmd_data)
  );

  AST_NO_START_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && half_tick && mod_in && !win_active) |=> !busy); // R1

  AST_MASKED_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && half_tick && (win_idx == '0 || win_idx == '1)) |=> !busy); // R2

  AST_VIOLATION_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && sym_viol) |=> (abort && !cmd_valid)); // R4

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && abort)); // R9

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R9

  AST_BUSY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cmd_valid || abort)); // R10

  AST_OUTCOME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || abort) |-> !busy); // R10
endmodule

// File: tb/sim_tag_cmd_rx.sv
module sim_tag_cmd_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_in = 1'b0;
  logic        half_tick = 1'b0;
  logic        win_active = 1'b0;
  logic [2:0]  win_idx = 3'd0;
  logic        has_data = 1'b0;
  logic        busy;
  logic        cmd_valid;
  logic        abort;
  logic [5:0]  cmd_code;
  logic [31:0] cmd_data;

  always #5 clk = ~clk;

  tag_cmd_rx u0 (
    .clk(clk), .rst_n(rst_n), .mod_in(mod_in), .half_tick(half_tick),
    .win_active(win_active), .win_idx(win_idx), .has_data(has_data),
    .busy(busy), .cmd_valid(cmd_valid), .abort(abort),
    .cmd_code(cmd_code), .cmd_data(cmd_data)
  );

  int checks = 0;
  int fails = 0;
  int n_valid = 0;
  int n_abort = 0;
  int n_both = 0;
  logic [5:0]  got_code = '0;
  logic [31:0] got_data = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_valid++;
      got_code = cmd_code;
      got_data = cmd_data;
    end
    if (abort) n_abort++;
    if (cmd_valid && abort) n_both++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic half(input logic m);
    @(negedge clk);
    mod_in = m;
    half_tick = 1'b1;
    @(negedge clk);
    half_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    if (b) begin half(1'b0); half(1'b1); end
    else   begin half(1'b1); half(1'b0); end
  endtask

  task automatic open_start(input logic [2:0] idx);
    win_active = 1'b1;
    win_idx = idx;
    half(1'b1);
    win_active = 1'b0;
  endtask

  task automatic send_cmd(input logic [5:0] c, input logic [31:0] d, input logic hd,
                          input logic flip, input logic [2:0] idx);
    has_data = hd;
    open_start(idx);
    half(1'b0);
    for (int i = 5; i >= 0; i--) send_bit(c[i]);
    if (hd) begin
      for (int i = 31; i >= 0; i--) send_bit(d[i]);
      send_bit((^{c, d}) ^ flip);
    end
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic [5:0]  c;
    logic [31:0] d;
    logic        hd;
    logic        flip;
    logic [2:0]  idx;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{6'h2A, 32'hDEADBEEF, 1'b1, 1'b0, 3'd1},
    '{6'h01, 32'h00000000, 1'b1, 1'b0, 3'd6},
    '{6'h3F, 32'hFFFFFFFF, 1'b1, 1'b1, 3'd3},
    '{6'h15, 32'h12345678, 1'b0, 1'b0, 3'd4},
    '{6'h20, 32'h80000001, 1'b1, 1'b0, 3'd2},
    '{6'h0C, 32'hA5A5A5A4, 1'b1, 1'b1, 3'd5}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 busy", busy, 0);
    chk("R11 valid/abort", {cmd_valid, abort}, 0);
    chk("R11 code/data", {cmd_code, cmd_data}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R5 R6 R7 R8 R2 (positions 1 and 6)
    foreach (VECS[k]) begin
      int v0, a0;
      logic exp_ok;
      v0 = n_valid;
      a0 = n_abort;
      exp_ok = !(VECS[k].hd && VECS[k].flip);
      send_cmd(VECS[k].c, VECS[k].d, VECS[k].hd, VECS[k].flip, VECS[k].idx);
      if (exp_ok) begin
        chk("R7 valid count", n_valid - v0, 1);
        chk("R8 no abort", n_abort - a0, 0);
        chk("R5 code", got_code, VECS[k].c);
        chk("R6/R7 data", got_data, VECS[k].hd ? VECS[k].d : 32'h0);
      end else begin
        chk("R8 abort count", n_abort - a0, 1);
        chk("R8 no valid", n_valid - v0, 0);
      end
      chk("R10 idle after", busy, 0);
    end

    // R1: modulation outside the window is ignored
    begin
      int v0, a0;
      v0 = n_valid; a0 = n_abort;
      win_active = 1'b0; win_idx = 3'd3;
      half(1'b1);
      chk("R1 busy stays low", busy, 0);
      half(1'b0);
      send_bit(1'b1);
      chk("R1 no strobes", {n_valid - v0, n_abort - a0}, 0);
    end

    // R2: positions 0 and 7 masked
    begin
      int v0, a0;
      v0 = n_valid; a0 = n_abort;
      open_start(3'd0);
      chk("R2 position 0 masked", busy, 0);
      half(1'b0);
      open_start(3'd7);
      chk("R2 position 7 masked", busy, 0);
      half(1'b0);
      chk("R2 no strobes", {n_valid - v0, n_abort - a0}, 0);
    end

    // R10: busy during reception, R3: bad start marker
    begin
      int a0;
      a0 = n_abort;
      open_start(3'd2);
      chk("R10 busy after start", busy, 1);
      half(1'b1);
      repeat (2) @(negedge clk);
      chk("R3 bad marker aborts", n_abort - a0, 1);
      chk("R3 idle after abort", busy, 0);
    end

    // R4: equal halves mid-command
    begin
      int a0, v0;
      a0 = n_abort; v0 = n_valid;
      has_data = 1'b0;
      open_start(3'd3);
      half(1'b0);
      send_bit(1'b1);
      send_bit(1'b0);
      half(1'b0);
      half(1'b0);
      repeat (2) @(negedge clk);
      chk("R4 violation aborts", n_abort - a0, 1);
      chk("R4 no valid", n_valid - v0, 0);
      chk("R4 idle", busy, 0);
    end

    // R10: completion coinciding with a qualified-looking start
    begin
      int a0, v0;
      logic [5:0]  c;
      logic [31:0] d;
      c = 6'h11; d = 32'h00000001;   // parity bit = 1 -> second half modulated
      a0 = n_abort; v0 = n_valid;
      has_data = 1'b1;
      open_start(3'd1);
      half(1'b0);
      for (int i = 5; i >= 0; i--) send_bit(c[i]);
      for (int i = 31; i >= 0; i--) send_bit(d[i]);
      half(1'b0);
      win_active = 1'b1; win_idx = 3'd3;
      half(1'b1);
      win_active = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 single valid at overlap", n_valid - v0, 1);
      chk("R10 no abort at overlap", n_abort - a0, 0);
      chk("R10 not restarted", busy, 0);
      chk("R7 overlap data", {got_code, got_data}, {c, d});
    end

    chk("R9 never both", n_both, 0);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule